// File: doc/BRIEF.md
# Taken-Branch History Ring Buffer

This block keeps a short history of taken branches. Each time the core reports a taken branch with a valid strobe, the block can store the source and target addresses in a circular buffer whose depth is a power of two. A top-of-stack pointer always names the slot that was written most recently. The slot holding the record that is i branches older than the newest is therefore `(tos - i) & (DEPTH-1)`.

Software controls the block through a two-bit control word. Bit 0 enables recording and bit 1 selects freeze-on-interrupt. Both bits are normally written together to arm or disarm the block. When freeze is selected and the performance-monitoring interrupt line goes high, recording stops at once. The pointer then holds its value, so the history stays stable while a handler reads it. The frozen state is latched and ends only when the control word is written again.

A registered read port returns a source word, a target word, the pointer, or the control word for a chosen index. A clear pulse zeroes every stored entry. A build-time parameter chooses one of two record layouts: a packed 32-bit layout or a 64-bit layout that carries a mispredict flag. For the 64-bit layout, the read path also presents the source address with the flag removed and sign-extended.

Top module: `brhist_ring`

## Requirements
- R1: After reset, every stored entry reads as zero, the pointer (read select 2) reads zero, and the control word (read select 3) reads zero.
- R2: A cycle with `br_valid` high captures the branch when all of the following hold: recording is enabled, the block is not frozen, `clr` is low, and freeze-with-interrupt is not active in that cycle. On a capture, the pointer first advances by one modulo DEPTH, and the record is then written at the new pointer value.
- R3: While the enable bit (control bit 0) is zero, `br_valid` has no effect: the entries and the pointer keep their values.
- R4: When the freeze bit (control bit 1) is set and `pmi` is high, no branch is captured in that cycle. The block then stays frozen with no captures after `pmi` falls, until the next control write.
- R5: When the freeze bit is zero, `pmi` has no effect on capture.
- R6: Packed layout (`WIDE_FMT=0`): read select 0 returns `{target[31:0], source[31:0]}` for the indexed slot, and read select 1 returns zero.
- R7: Wide layout (`WIDE_FMT=1`): read select 0 returns `{mispredict, source[62:0]}`, and read select 1 returns the full 64-bit target.
- R8: `rd_flag` equals bit 63 of `rd_data`. `rd_addr` equals bits 62:0 of `rd_data` sign-extended from bit 62.
- R9: A `clr` pulse zeroes every source and target entry and leaves the pointer unchanged. A branch presented in the same cycle as `clr` is dropped.
- R10: A read with `rd_en` high appears on `rd_data` one cycle later. It shows the state before any capture, clear or control write made in the same cycle.
- R11: Read select 3 returns bit 0 = enable, bit 1 = freeze and bit 2 = frozen, with all other bits zero. Read select 2 returns the pointer, zero-extended.
- R12: The pointer wraps from DEPTH-1 to 0 on a capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_valid | input | 1 | Taken-branch strobe |
| br_src | input | 64 | Branch source address |
| br_dst | input | 64 | Branch target address |
| br_mis | input | 1 | Branch was mispredicted |
| pmi | input | 1 | Performance-monitoring interrupt level |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 2 | Control word: bit 0 enable, bit 1 freeze |
| clr | input | 1 | Zero all entries |
| rd_en | input | 1 | Read request |
| rd_sel | input | 2 | 0 source word, 1 target word, 2 pointer, 3 control |
| rd_idx | input | $clog2(DEPTH) | Entry index for selects 0 and 1 |
| rd_data | output | 64 | Registered read result |
| rd_addr | output | 64 | `rd_data` source with flag removed, sign-extended |
| rd_flag | output | 1 | Mispredict flag taken from `rd_data` |

## Verification
The bench builds two copies side by side. One is a four-entry wide-layout copy, so the pointer wraps after a handful of branches and the mispredict flag and sign extension can be observed. The other is an eight-entry packed-layout copy, which checks the 32-bit packing and shows that select 1 reads zero. Both copies receive the same stimulus and sweep their read ports every cycle. This brings same-cycle read/capture collisions and clear/capture collisions within reach for both depths.

// File: rtl/brh_pkg.sv
package brh_pkg;

  typedef enum logic [1:0] {
    RD_SRC = 2'd0,
    RD_DST = 2'd1,
    RD_TOS = 2'd2,
    RD_CTL = 2'd3
  } rd_sel_e;

  // Place the mispredict flag above a 63-bit source address.
  function automatic logic [63:0] tag_src(input logic [63:0] addr, input logic mis);
    return {mis, addr[62:0]};
  endfunction

  // Drop the flag bit and sign-extend from bit 62.
  function automatic logic [63:0] strip_src(input logic [63:0] word);
    return {word[62], word[62:0]};
  endfunction

  // Packed record: target in the upper half, source in the lower half.
  function automatic logic [63:0] pack32(input logic [31:0] src, input logic [31:0] dst);
    return {dst, src};
  endfunction

endpackage

// File: rtl/brh_ctl.sv
module brh_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_we,
  input  logic [1:0] ctl_wdata,
  input  logic       pmi,
  output logic       ctl_en,
  output logic       ctl_frz,
  output logic       frozen,
  output logic       rec_ok
);

  logic en_q, frz_q, frozen_q;
  logic frz_hit;

  assign frz_hit = frz_q & pmi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      frz_q    <= 1'b0;
      frozen_q <= 1'b0;
    end else begin
      if (ctl_we) begin
        en_q     <= ctl_wdata[0];
        frz_q    <= ctl_wdata[1];
        frozen_q <= 1'b0;
      end else if (frz_q) begin
        frozen_q <= frozen_q | pmi;
      end else begin
        frozen_q <= 1'b0;
      end
    end
  end

  assign ctl_en  = en_q;
  assign ctl_frz = frz_q;
  assign frozen  = frozen_q;
  assign rec_ok  = en_q & ~frozen_q & ~frz_hit;

endmodule

// File: rtl/brh_ptr.sv
module brh_ptr #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [IDX_W-1:0] tos,
  output logic [IDX_W-1:0] tos_nxt
);

  localparam logic [IDX_W-1:0] MASK = IDX_W'(DEPTH - 1);

  function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] t);
    return (t + IDX_W'(1)) & MASK;
  endfunction

  logic [IDX_W-1:0] tos_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   tos_q <= '0;
    else if (adv) tos_q <= step(tos_q);
  end

  assign tos     = tos_q;
  assign tos_nxt = step(tos_q);

endmodule

// File: rtl/brh_store.sv
module brh_store #(
  parameter int DEPTH    = 8,
  parameter bit WIDE_FMT = 1'b1,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [63:0]      br_src,
  input  logic [63:0]      br_dst,
  input  logic             br_mis,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [63:0]      word_a,
  output logic [63:0]      word_b
);
  import brh_pkg::*;

  generate
    if (WIDE_FMT) begin : g_wide
      logic [63:0] src_m [DEPTH];
      logic [63:0] dst_m [DEPTH];
      logic        unused_w;
      assign unused_w = br_src[63];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < DEPTH; i++) begin
            src_m[i] <= '0;
            dst_m[i] <= '0;
          end
        end else if (clr) begin
          for (int i = 0; i < DEPTH; i++) begin
            src_m[i] <= '0;
            dst_m[i] <= '0;
          end
        end else if (wr_en) begin
          src_m[wr_idx] <= tag_src(br_src, br_mis);
          dst_m[wr_idx] <= br_dst;
        end
      end

      assign word_a = src_m[rd_idx];
      assign word_b = dst_m[rd_idx];
    end else begin : g_packed
      logic [31:0] src_m [DEPTH];
      logic [31:0] dst_m [DEPTH];
      logic        unused_p;
      assign unused_p = ^{br_src[63:32], br_dst[63:32], br_mis};

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < DEPTH; i++) begin
            src_m[i] <= '0;
            dst_m[i] <= '0;
          end
        end else if (clr) begin
          for (int i = 0; i < DEPTH; i++) begin
            src_m[i] <= '0;
            dst_m[i] <= '0;
          end
        end else if (wr_en) begin
          src_m[wr_idx] <= br_src[31:0];
          dst_m[wr_idx] <= br_dst[31:0];
        end
      end

      assign word_a = pack32(src_m[rd_idx], dst_m[rd_idx]);
      assign word_b = '0;
    end
  endgenerate

endmodule

// File: rtl/brhist_ring.sv
module brhist_ring #(
  parameter int DEPTH    = 8,
  parameter bit WIDE_FMT = 1'b1,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             br_valid,
  input  logic [63:0]      br_src,
  input  logic [63:0]      br_dst,
  input  logic             br_mis,
  input  logic             pmi,
  input  logic             ctl_we,
  input  logic [1:0]       ctl_wdata,
  input  logic             clr,
  input  logic             rd_en,
  input  logic [1:0]       rd_sel,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [63:0]      rd_data,
  output logic [63:0]      rd_addr,
  output logic             rd_flag
);
  import brh_pkg::*;

  if (DEPTH != 4 && DEPTH != 8 && DEPTH != 16) begin : g_bad_depth
    $error("brhist_ring: DEPTH must be 4, 8 or 16");
  end

  logic             ctl_en, ctl_frz, frozen, rec_ok;
  logic             cap_fire;
  logic [IDX_W-1:0] tos, tos_nxt;
  logic [63:0]      word_a, word_b;
  logic [63:0]      rd_mux, rd_q;

  brh_ctl u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_we    (ctl_we),
    .ctl_wdata (ctl_wdata),
    .pmi       (pmi),
    .ctl_en    (ctl_en),
    .ctl_frz   (ctl_frz),
    .frozen    (frozen),
    .rec_ok    (rec_ok)
  );

  // Named capture event, also observed by the checker.
  assign cap_fire = br_valid & rec_ok & ~clr;

  brh_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (cap_fire),
    .tos     (tos),
    .tos_nxt (tos_nxt)
  );

  brh_store #(.DEPTH(DEPTH), .WIDE_FMT(WIDE_FMT)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr),
    .wr_en  (cap_fire),
    .wr_idx (tos_nxt),
    .br_src (br_src),
    .br_dst (br_dst),
    .br_mis (br_mis),
    .rd_idx (rd_idx),
    .word_a (word_a),
    .word_b (word_b)
  );

  always_comb begin
    unique case (rd_sel)
      RD_SRC:  rd_mux = word_a;
      RD_DST:  rd_mux = word_b;
      RD_TOS:  rd_mux = {{(64-IDX_W){1'b0}}, tos};
      default: rd_mux = {61'b0, frozen, ctl_frz, ctl_en};
    endcase
  end

  // Sampled from pre-edge state, so a same-cycle capture is not visible.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= rd_mux;
  end

  assign rd_data = rd_q;
  assign rd_addr = strip_src(rd_q);
  assign rd_flag = rd_q[63];

endmodule

// File: rtl/brhist_ring_chk.sv
module brhist_ring_chk #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             br_valid,
  input logic             pmi,
  input logic             clr,
  input logic             ctl_we,
  input logic             ctl_en,
  input logic             ctl_frz,
  input logic             frozen,
  input logic             cap_fire,
  input logic [IDX_W-1:0] tos
);

  // R2 / R12: a capture moves the pointer one step, wrapping at DEPTH.
  p_tos_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cap_fire |=> tos == IDX_W'(($past(tos) + 1) % DEPTH));

  // R9: with no capture, the pointer holds, clear included.
  p_tos_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_fire |=> $stable(tos));

  // R3: capture needs the enable bit.
  p_enable_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en |-> !cap_fire);

  // R4: freeze with interrupt blocks capture in the same cycle.
  p_pmi_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_frz && pmi) |-> !cap_fire);

  // R4: a frozen block never captures.
  p_frozen_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |-> !cap_fire);

  // R4: frozen stays latched until a control write.
  p_frozen_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && ctl_frz && !ctl_we) |=> frozen);

  // R9: clear drops a same-cycle branch.
  p_clear_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && br_valid) |-> !cap_fire);

endmodule

bind brhist_ring brhist_ring_chk #(.DEPTH(DEPTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .br_valid (br_valid),
  .pmi      (pmi),
  .clr      (clr),
  .ctl_we   (ctl_we),
  .ctl_en   (ctl_en),
  .ctl_frz  (ctl_frz),
  .frozen   (frozen),
  .cap_fire (cap_fire),
  .tos      (tos)
);

// File: tb/brhist_ring_tb_top.sv
module brhist_ring_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        br_valid = 1'b0;
  logic [63:0] br_src = '0, br_dst = '0;
  logic        br_mis = 1'b0;
  logic        pmi = 1'b0;
  logic        ctl_we = 1'b0;
  logic [1:0]  ctl_wdata = '0;
  logic        clr = 1'b0;
  logic        rd_en = 1'b1;
  logic [1:0]  rd_sel = '0;
  logic [1:0]  ridx_w = '0;
  logic [2:0]  ridx_p = '0;
  logic [63:0] rdat_w, raddr_w, rdat_p, raddr_p;
  logic        rflag_w, rflag_p;

  always #10 clk = ~clk;

  brhist_ring #(.DEPTH(4), .WIDE_FMT(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_src(br_src), .br_dst(br_dst),
    .br_mis(br_mis), .pmi(pmi), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .clr(clr),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_idx(ridx_w),
    .rd_data(rdat_w), .rd_addr(raddr_w), .rd_flag(rflag_w));

  brhist_ring #(.DEPTH(8), .WIDE_FMT(1'b0)) dut_p (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_src(br_src), .br_dst(br_dst),
    .br_mis(br_mis), .pmi(pmi), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .clr(clr),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_idx(ridx_p),
    .rd_data(rdat_p), .rd_addr(raddr_p), .rd_flag(rflag_p));

  // Behavioural reference: k=0 wide/4 entries, k=1 packed/8 entries.
  logic [63:0] m_src [2][16];
  logic [63:0] m_dst [2][16];
  int          m_tos [2];
  int          dep   [2] = '{4, 8};
  bit          m_en, m_frz, m_frozen;
  logic [63:0] exp_q [2];
  int          vecs = 0, fails = 0, sweep = 0;
  string       cur_req = "R1";

  function automatic logic [63:0] mread(int k, int sel, int idx);
    int i = idx % dep[k];
    case (sel)
      0: mread = (k == 0) ? m_src[k][i] : {m_dst[k][i][31:0], m_src[k][i][31:0]};
      1: mread = (k == 0) ? m_dst[k][i] : 64'd0;
      2: mread = 64'(m_tos[k]);
      default: mread = {61'd0, m_frozen, m_frz, m_en};
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 2; k++) begin
        for (int i = 0; i < 16; i++) begin m_src[k][i] = 0; m_dst[k][i] = 0; end
        m_tos[k] = 0; exp_q[k] = 0;
      end
      m_en = 0; m_frz = 0; m_frozen = 0;
    end else begin
      bit cap;
      if (rd_en) begin
        exp_q[0] = mread(0, int'(rd_sel), int'(ridx_w));
        exp_q[1] = mread(1, int'(rd_sel), int'(ridx_p));
      end
      cap = br_valid && m_en && !m_frozen && !(m_frz && pmi) && !clr;
      if (ctl_we) m_frozen = 0;
      else if (m_frz) m_frozen = m_frozen || pmi;
      else m_frozen = 0;
      for (int k = 0; k < 2; k++) begin
        if (clr) begin
          for (int i = 0; i < 16; i++) begin m_src[k][i] = 0; m_dst[k][i] = 0; end
        end else if (cap) begin
          m_tos[k] = (m_tos[k] + 1) % dep[k];
          if (k == 0) begin
            m_src[k][m_tos[k]] = {br_mis, br_src[62:0]};
            m_dst[k][m_tos[k]] = br_dst;
          end else begin
            m_src[k][m_tos[k]] = {32'd0, br_src[31:0]};
            m_dst[k][m_tos[k]] = {32'd0, br_dst[31:0]};
          end
        end
      end
      if (ctl_we) begin m_en = ctl_wdata[0]; m_frz = ctl_wdata[1]; end
    end
  end

  task automatic check64(string what, logic [63:0] act, logic [63:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    logic [63:0] sx;
    check64("wide rd_data (R7 R10)", rdat_w, exp_q[0]);
    check64("packed rd_data (R6 R10)", rdat_p, exp_q[1]);
    sx = exp_q[0][62] ? {1'b1, exp_q[0][62:0]} : {1'b0, exp_q[0][62:0]};
    check64("wide rd_addr (R8)", raddr_w, sx);
    check64("wide rd_flag (R8)", {63'd0, rflag_w}, {63'd0, exp_q[0][63]});
  endtask

  task automatic tick(bit v, bit p, bit c, bit we, logic [1:0] wd);
    @(negedge clk);
    compare_all();
    br_valid = v; pmi = p; clr = c; ctl_we = we; ctl_wdata = wd;
    br_src = {$urandom, $urandom}; br_dst = {$urandom, $urandom}; br_mis = $urandom;
    sweep++;
    rd_sel = 2'(sweep % 4);
    ridx_w = 2'(sweep / 4);
    ridx_p = 3'(sweep / 4);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick(0, 0, 0, 0, 2'b00);
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    cur_req = "R1"; idle(40);          // R1 and R11: zero state on all selects
    cur_req = "R3"; for (int i = 0; i < 12; i++) tick(1, 0, 0, 0, 2'b00);
    idle(40);
    cur_req = "R2"; tick(0, 0, 0, 1, 2'b01);
    for (int i = 0; i < 10; i++) tick(1, 0, 0, 0, 2'b00);  // R12 wrap in both depths
    idle(40);
    cur_req = "R5"; for (int i = 0; i < 6; i++) tick(1, 1, 0, 0, 2'b00);
    idle(40);
    cur_req = "R4"; tick(0, 0, 0, 1, 2'b11);
    tick(1, 0, 0, 0, 2'b00);
    tick(1, 1, 0, 0, 2'b00);           // blocked same cycle
    for (int i = 0; i < 6; i++) tick(1, 0, 0, 0, 2'b00);  // stays frozen
    idle(40);
    tick(0, 0, 0, 1, 2'b11);           // rearm leaves frozen state
    for (int i = 0; i < 3; i++) tick(1, 0, 0, 0, 2'b00);
    idle(40);
    cur_req = "R9"; tick(1, 0, 1, 0, 2'b00);
    idle(40);
    cur_req = "R10";
    for (int i = 0; i < 64; i++) tick(1, 0, 0, 0, 2'b00);
    cur_req = "R11"; tick(0, 0, 0, 1, 2'b10); idle(8);
    tick(0, 1, 0, 0, 2'b00); idle(8);
    cur_req = "R6 R7 R8";
    tick(0, 0, 0, 1, 2'b01);
    for (int i = 0; i < 800; i++)
      tick($urandom % 4 != 0, $urandom % 16 == 0, $urandom % 64 == 0,
           $urandom % 32 == 0, 2'($urandom));
    idle(40);
    report();
    $finish;
  end

endmodule